// File: doc/BRIEF.md
# Per-Bank DRAM Command Timing Tracker

This block follows one DRAM bank through its two states, idle and row open, and enforces the minimum spacing that commands inside that bank must keep. A scheduler presents one command per cycle on a valid strobe. Each cycle the block reports, through four allow flags, which command kinds may legally go out in that cycle. The scheduler selects only among allowed kinds. A command presented while its flag is low is refused and reported.

Each spacing rule has its own down-counter. The counter reloads from a programmable cycle count when its reference command is accepted. The write-related rules are measured from the end of the write data burst, which falls a write-latency plus a burst length after the write command. A command kind is allowed only when the bank state permits it and every counter that guards it has drained. All spacing values come in on configuration inputs, which are held stable during operation. The burst length, in clock cycles, is a parameter.

Top module: `bank_timing_tracker`

## Requirements
- R1: After reset the bank is idle, all counters are clear, the activate flag is high, the read, write and precharge flags are low, and the violation output is low.
- R2: Read and write are allowed from the cycle that lies rcdCycles clock cycles after an accepted activate.
- R3: Precharge is allowed no earlier than rasCycles cycles after the accepted activate that opened the row.
- R4: Activate is allowed from rpCycles cycles after an accepted precharge. Back-to-back activates are therefore spaced by at least rasCycles + rpCycles cycles.
- R5: Two accepted column commands (read or write, in any mix) are spaced by at least ccdCycles cycles.
- R6: A read is allowed no earlier than cwdCycles + BURST_LEN + wtrCycles cycles after an accepted write.
- R7: A precharge is allowed no earlier than cwdCycles + BURST_LEN + wrCycles cycles after an accepted write.
- R8: The command code on cmdKind is 0 = activate, 1 = read, 2 = write, 3 = precharge. Read, write and precharge are never allowed while the bank is idle, and activate is never allowed while a row is open. An accepted activate opens the row and an accepted precharge closes it.
- R9: A presented command whose flag is low raises violation for exactly the following cycle. The refused command changes neither the bank state nor any counter. An accepted command leaves violation low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is presented this cycle |
| cmdKind | input | 2 | Command code: 0 activate, 1 read, 2 write, 3 precharge |
| rcdCycles | input | T_W | Activate-to-column spacing |
| rasCycles | input | T_W | Activate-to-precharge spacing |
| rpCycles | input | T_W | Precharge-to-activate spacing |
| ccdCycles | input | T_W | Column-to-column spacing |
| cwdCycles | input | T_W | Write command to first write data |
| wrCycles | input | T_W | Write burst end to precharge |
| wtrCycles | input | T_W | Write burst end to read |
| actOk | output | 1 | Activate may be issued this cycle |
| rdOk | output | 1 | Read may be issued this cycle |
| wrOk | output | 1 | Write may be issued this cycle |
| preOk | output | 1 | Precharge may be issued this cycle |
| rowOpen | output | 1 | A row is open in the bank |
| violation | output | 1 | A refused command was presented in the previous cycle |

## Verification
The assertions check the state rules on every cycle. No column command or precharge is allowed while the bank is idle, and no activate is allowed while a row is open. They also check that accepted activates and precharges move the bank state, that a refused command produces the one-cycle violation, that an accepted command never does, and that read stays blocked right after an activate. The exact spacing values need the bench's scenarios: activate to column, activate to precharge, the full activate-to-activate cycle, column to column, and the write-burst-end spacings for read and precharge. The bench scenarios also show that a refused command leaves every counter as it was, which they see from the cycle in which a later flag rises.

// File: rtl/bank_timing_pkg.sv
`timescale 1ns/1ps
package bank_timing_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  // strobes from control to datapath, one per accepted event
  typedef struct packed {
    logic actGo;
    logic colGo;
    logic wrGo;
    logic preGo;
  } strobe_t;

  localparam int NUM_CNT  = 6;
  localparam int CNT_RCD  = 0;
  localparam int CNT_RAS  = 1;
  localparam int CNT_RP   = 2;
  localparam int CNT_CCD  = 3;
  localparam int CNT_WREC = 4;
  localparam int CNT_WTR  = 5;

endpackage

// File: rtl/bank_spacing_counter.sv
`timescale 1ns/1ps
module bank_spacing_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic         zero
);
  logic [W-1:0] cnt;

  // a spacing of N loads N-1, so the guarded command opens N cycles later
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (loadVal == '0) ? '0 : loadVal - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/bank_timing_datapath.sv
`timescale 1ns/1ps
module bank_timing_datapath
  import bank_timing_pkg::*;
#(
  parameter int T_W       = 6,
  parameter int BURST_LEN = 4,
  parameter int CW        = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             strobe,
  input  logic [T_W-1:0]      rcdCycles,
  input  logic [T_W-1:0]      rasCycles,
  input  logic [T_W-1:0]      rpCycles,
  input  logic [T_W-1:0]      ccdCycles,
  input  logic [T_W-1:0]      cwdCycles,
  input  logic [T_W-1:0]      wrCycles,
  input  logic [T_W-1:0]      wtrCycles,
  output logic [NUM_CNT-1:0]  zeroVec
);
  localparam logic [CW-1:0] BURST_CW = CW'(BURST_LEN);

  logic [NUM_CNT-1:0] loadVec;
  logic [CW-1:0]      valVec [NUM_CNT];
  logic [CW-1:0]      burstEnd;

  always_comb begin
    burstEnd         = CW'(cwdCycles) + BURST_CW;
    loadVec          = '0;
    loadVec[CNT_RCD]  = strobe.actGo;
    loadVec[CNT_RAS]  = strobe.actGo;
    loadVec[CNT_RP]   = strobe.preGo;
    loadVec[CNT_CCD]  = strobe.colGo;
    loadVec[CNT_WREC] = strobe.wrGo;
    loadVec[CNT_WTR]  = strobe.wrGo;
    valVec[CNT_RCD]   = CW'(rcdCycles);
    valVec[CNT_RAS]   = CW'(rasCycles);
    valVec[CNT_RP]    = CW'(rpCycles);
    valVec[CNT_CCD]   = CW'(ccdCycles);
    valVec[CNT_WREC]  = burstEnd + CW'(wrCycles);
    valVec[CNT_WTR]   = burstEnd + CW'(wtrCycles);
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    bank_spacing_counter #(.W(CW)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (loadVec[i]),
      .loadVal (valVec[i]),
      .zero    (zeroVec[i])
    );
  end
endmodule

// File: rtl/bank_timing_control.sv
`timescale 1ns/1ps
module bank_timing_control
  import bank_timing_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmdValid,
  input  logic [1:0]         cmdKind,
  input  logic [NUM_CNT-1:0] zeroVec,
  output strobe_t            strobe,
  output logic [3:0]         allowVec,
  output logic               rowOpen,
  output logic               violation
);
  cmd_e kind;
  logic accepted;

  always_comb begin
    kind              = cmd_e'(cmdKind);
    allowVec[CMD_ACT] = !rowOpen && zeroVec[CNT_RP];
    allowVec[CMD_WR]  = rowOpen && zeroVec[CNT_RCD] && zeroVec[CNT_CCD];
    allowVec[CMD_RD]  = allowVec[CMD_WR] && zeroVec[CNT_WTR];
    allowVec[CMD_PRE] = rowOpen && zeroVec[CNT_RAS] && zeroVec[CNT_WREC];
    accepted          = cmdValid && allowVec[kind];
    strobe.actGo      = accepted && (kind == CMD_ACT);
    strobe.preGo      = accepted && (kind == CMD_PRE);
    strobe.wrGo       = accepted && (kind == CMD_WR);
    strobe.colGo      = accepted && ((kind == CMD_RD) || (kind == CMD_WR));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rowOpen   <= 1'b0;
      violation <= 1'b0;
    end else begin
      violation <= cmdValid && !allowVec[kind];
      if (strobe.actGo) begin
        rowOpen <= 1'b1;
      end else if (strobe.preGo) begin
        rowOpen <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bank_timing_tracker.sv
`timescale 1ns/1ps
module bank_timing_tracker
  import bank_timing_pkg::*;
#(
  parameter int T_W       = 6,
  parameter int BURST_LEN = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmdValid,
  input  logic [1:0]     cmdKind,
  input  logic [T_W-1:0] rcdCycles,
  input  logic [T_W-1:0] rasCycles,
  input  logic [T_W-1:0] rpCycles,
  input  logic [T_W-1:0] ccdCycles,
  input  logic [T_W-1:0] cwdCycles,
  input  logic [T_W-1:0] wrCycles,
  input  logic [T_W-1:0] wtrCycles,
  output logic           actOk,
  output logic           rdOk,
  output logic           wrOk,
  output logic           preOk,
  output logic           rowOpen,
  output logic           violation
);
  // wide enough for write latency + burst + recovery
  localparam int CW = $clog2(2 * (2 ** T_W) + BURST_LEN + 1);

  strobe_t            strobe;
  logic [NUM_CNT-1:0] zeroVec;
  logic [3:0]         allowVec;

  bank_timing_control u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmdValid  (cmdValid),
    .cmdKind   (cmdKind),
    .zeroVec   (zeroVec),
    .strobe    (strobe),
    .allowVec  (allowVec),
    .rowOpen   (rowOpen),
    .violation (violation)
  );

  bank_timing_datapath #(.T_W(T_W), .BURST_LEN(BURST_LEN), .CW(CW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .rcdCycles (rcdCycles),
    .rasCycles (rasCycles),
    .rpCycles  (rpCycles),
    .ccdCycles (ccdCycles),
    .cwdCycles (cwdCycles),
    .wrCycles  (wrCycles),
    .wtrCycles (wtrCycles),
    .zeroVec   (zeroVec)
  );

  assign actOk = allowVec[CMD_ACT];
  assign rdOk  = allowVec[CMD_RD];
  assign wrOk  = allowVec[CMD_WR];
  assign preOk = allowVec[CMD_PRE];
endmodule

// File: rtl/bank_timing_checker.sv
`timescale 1ns/1ps
module bank_timing_checker #(
  parameter int T_W = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmdValid,
  input logic [1:0]     cmdKind,
  input logic [T_W-1:0] rcdCycles,
  input logic           actOk,
  input logic           rdOk,
  input logic           wrOk,
  input logic           preOk,
  input logic           rowOpen,
  input logic           violation
);
  logic kindOk;
  always_comb begin
    case (cmdKind)
      2'd0:    kindOk = actOk;
      2'd1:    kindOk = rdOk;
      2'd2:    kindOk = wrOk;
      default: kindOk = preOk;
    endcase
  end

  AST_IDLE_BLOCKS_COL: assert property (@(posedge clk) disable iff (!rst_n)
    !rowOpen |-> !(rdOk || wrOk || preOk)); // R8
  AST_OPEN_BLOCKS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    rowOpen |-> !actOk); // R8
  AST_ACT_OPENS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdKind == 2'd0 && actOk) |=> rowOpen); // R8
  AST_PRE_CLOSES_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdKind == 2'd3 && preOk) |=> !rowOpen); // R8
  AST_REFUSED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && !kindOk) |=> violation); // R9
  AST_ACCEPTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && kindOk) |=> !violation); // R9
  AST_NO_EARLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rowOpen) && rcdCycles > 1) |-> !rdOk); // R2
endmodule

bind bank_timing_tracker bank_timing_checker #(.T_W(T_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmdValid  (cmdValid),
  .cmdKind   (cmdKind),
  .rcdCycles (rcdCycles),
  .actOk     (actOk),
  .rdOk      (rdOk),
  .wrOk      (wrOk),
  .preOk     (preOk),
  .rowOpen   (rowOpen),
  .violation (violation)
);

// File: tb/bank_timing_tracker_bench.sv
`timescale 1ns/1ps
module bank_timing_tracker_bench;
  localparam int T_W   = 6;
  localparam int BL    = 4;
  localparam int RCD   = 3;
  localparam int RAS   = 8;
  localparam int RP    = 4;
  localparam int CCD   = 2;
  localparam int CWD   = 2;
  localparam int WR    = 3;
  localparam int WTR   = 2;
  localparam int WIN   = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdKind = 2'd0;
  logic actOk, rdOk, wrOk, preOk, rowOpen, violation;

  int checks = 0;
  int fails = 0;
  int firstAct, firstRd, firstWr, firstPre;

  always #4 clk = ~clk;

  bank_timing_tracker #(.T_W(T_W), .BURST_LEN(BL)) u_bank_timing_tracker (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .rcdCycles(T_W'(RCD)), .rasCycles(T_W'(RAS)), .rpCycles(T_W'(RP)),
    .ccdCycles(T_W'(CCD)), .cwdCycles(T_W'(CWD)), .wrCycles(T_W'(WR)),
    .wtrCycles(T_W'(WTR)),
    .actOk(actOk), .rdOk(rdOk), .wrOk(wrOk), .preOk(preOk),
    .rowOpen(rowOpen), .violation(violation)
  );

  task automatic check(input int got, input int exp, input string req, input string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the command edge
  task automatic issue(input logic [1:0] k);
    cmdValid = 1'b1;
    cmdKind  = k;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  // cycle index (1 = first cycle after the command) at which each flag first rises
  task automatic observe();
    firstAct = 0; firstRd = 0; firstWr = 0; firstPre = 0;
    for (int k = 1; k <= WIN; k++) begin
      if (actOk && firstAct == 0) firstAct = k;
      if (rdOk  && firstRd  == 0) firstRd  = k;
      if (wrOk  && firstWr  == 0) firstWr  = k;
      if (preOk && firstPre == 0) firstPre = k;
      if (k < WIN) @(negedge clk);
    end
  endtask

  task automatic test_reset();
    check(int'(actOk), 1, "R1", "actOk after reset");
    check(int'(rdOk || wrOk || preOk), 0, "R1", "column/precharge flags after reset");
    check(int'(rowOpen), 0, "R1", "rowOpen after reset");
    check(int'(violation), 0, "R1", "violation after reset");
  endtask

  task automatic test_activate();
    issue(2'd0);
    check(int'(rowOpen), 1, "R8", "rowOpen after activate");
    observe();
    check(firstRd, RCD, "R2", "read delay after activate");
    check(firstWr, RCD, "R2", "write delay after activate");
    check(firstPre, RAS, "R3", "precharge delay after activate");
    check(firstAct, 0, "R8", "activate while open");
  endtask

  task automatic test_precharge();
    issue(2'd3);
    check(int'(rowOpen), 0, "R8", "rowOpen after precharge");
    observe();
    check(firstAct, RP, "R4", "activate delay after precharge");
    check(firstRd + firstWr + firstPre, 0, "R8", "column/precharge while idle");
  endtask

  task automatic test_row_cycle();
    int k;
    int j;
    issue(2'd0);
    k = 1;
    while (!preOk && k < WIN) begin @(negedge clk); k++; end
    issue(2'd3);
    j = 1;
    while (!actOk && j < WIN) begin @(negedge clk); j++; end
    check(k + j, RAS + RP, "R4", "activate-to-activate spacing");
    issue(2'd0);
    observe();
  endtask

  task automatic test_column_spacing();
    issue(2'd1);
    observe();
    check(firstRd, CCD, "R5", "read-to-read spacing");
    check(firstWr, CCD, "R5", "read-to-write spacing");
  endtask

  task automatic test_write_turnaround();
    issue(2'd2);
    observe();
    check(firstWr, CCD, "R5", "write-to-write spacing");
    check(firstRd, CWD + BL + WTR, "R6", "write-to-read spacing");
    check(firstPre, CWD + BL + WR, "R7", "write-to-precharge spacing");
  endtask

  task automatic test_refusals();
    // activate with row open
    issue(2'd0);
    check(int'(violation), 1, "R9", "violation after activate while open");
    check(int'(rowOpen), 1, "R9", "row stays open after refused activate");
    check(int'(rdOk), 1, "R9", "read still allowed after refused activate");
    @(negedge clk);
    check(int'(violation), 0, "R9", "violation lasts one cycle");
    issue(2'd3);
    check(int'(violation), 0, "R9", "no violation after accepted precharge");
    issue(2'd1);
    check(int'(violation), 1, "R8", "violation after read while idle");
    check(int'(rowOpen), 0, "R9", "row stays idle after refused read");
    issue(2'd3);
    check(int'(violation), 1, "R8", "violation after precharge while idle");
    while (!actOk) @(negedge clk);
    issue(2'd0);
    issue(2'd2);
    check(int'(violation), 1, "R9", "violation after early write");
    observe();
    check(firstWr, RCD - 1, "R9", "refused write left spacing unchanged");
    check(firstPre, RAS - 1, "R9", "refused write loaded no recovery");
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_activate();
    test_precharge();
    test_row_cycle();
    test_column_spacing();
    test_write_turnaround();
    test_refusals();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule